// File: doc/BRIEF.md
# Trap and Interrupt Control Registers

This unit holds the machine-level trap state of a small 32-bit RISC-V style core. It keeps one external-interrupt enable bit with a single save slot, a trap cause word, the exception return address and the trap vector. The pipeline reaches these registers through a small CSR port. The port takes a 12-bit address, write data, a swap-operation flag and an enable, and it returns the old value of the register in the same cycle.

Each cycle the core reports its trap conditions: the external interrupt line, an illegal-instruction flag, ecall and ebreak, the PC to record, and an mret strobe. The unit decides whether a trap is taken and records its cause. It tells the fetch stage where to go next: the trap vector on a trap, or the saved return address on mret. A CSR access whose form or address is not supported raises an illegal-instruction trap through the same path.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset, the interrupt enable and its saved copy are 0, CAUSE and EPC read 0, and EVECT reads the parameter VECT_DEFAULT (default 0x00000010).
- R2: The registers are STATUS (index 0), CAUSE (1), EPC (2) and EVECT (3). Each has a read-write alias at 0x7C0+index and a read-only alias at 0xFC0+index. An access with csr_en_i=1 and csr_swap_i=1 returns the current value on csr_rdata_o in that cycle. Through a read-write alias it stores csr_wdata_i at the next clock edge.
- R3: A swap through a read-only alias returns the current value and leaves every register unchanged.
- R4: An enabled access with csr_swap_i=0, or with an address outside the eight aliases, raises csr_illegal_o and trap_o with cause 0x00000002, and it writes nothing. In these cases csr_rdata_o is 0 whenever the address misses.
- R5: STATUS bit 0 is the enable, bit 1 is the saved enable, bit 2 shows ext_irq_i live, and bits 31:3 read 0. A write changes only bits 1:0.
- R6: CAUSE stores only bits 31 and 3:0. The codes are external interrupt 0x8000000B, illegal 0x00000002, ebreak 0x00000003 and ecall 0x0000000B.
- R7: When trap_o is 1, target_pc_o equals EVECT and redirect_o is 1. At the next edge the saved enable takes the old enable, the enable clears, EPC takes pc_i and CAUSE takes the code.
- R8: ext_irq_i causes a trap only while the enable is 1. Software traps are taken regardless of the enable.
- R9: A software trap wins over an external interrupt in the same cycle. Among software causes the order is illegal (instruction or CSR), then ebreak, then ecall.
- R10: mret_i without a trap gives redirect_o=1 and target_pc_o=EPC, and it copies the saved enable into the enable. A trap in the same cycle overrides mret.
- R11: A CSR write in a cycle that takes a trap is discarded.
- R12: EVECT is rewritable, and later traps go to the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_en_i | input | 1 | CSR access this cycle |
| csr_swap_i | input | 1 | Access is the swap form |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Data to store |
| csr_rdata_o | output | 32 | Old register value |
| csr_illegal_o | output | 1 | Unsupported CSR access |
| ext_irq_i | input | 1 | External interrupt request |
| illegal_instr_i | input | 1 | Illegal instruction decoded |
| ecall_i | input | 1 | Environment call |
| ebreak_i | input | 1 | Breakpoint |
| pc_i | input | 32 | PC recorded on a trap |
| mret_i | input | 1 | Return from trap |
| trap_o | output | 1 | Trap taken this cycle |
| redirect_o | output | 1 | Fetch must jump to target_pc_o |
| target_pc_o | output | 32 | Jump target |

## Verification
The assertions assume that the inputs are stable around the rising edge and that pc_i is meaningful whenever a trap can occur. They also assume that mret_i never comes with a STATUS write in the same cycle. When the two do coincide, the write wins and the restore check is skipped. The stimulus changes inputs only at the falling edge. It draws most CSR addresses from the eight aliases and only a few from random values. Ecall, ebreak, illegal and mret are kept rare, so that long runs of enabled interrupts and register swaps occur between traps.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_EVECT  = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic     hit;
    logic     ro;
    csr_sel_e sel;
  } csr_dec_t;

  localparam logic [3:0] CODE_ILLEGAL = 4'h2;
  localparam logic [3:0] CODE_EBREAK  = 4'h3;
  localparam logic [3:0] CODE_ECALL   = 4'hB;
  localparam logic [3:0] CODE_EXT_IRQ = 4'hB;
endpackage

// File: rtl/trap_csr_decode.sv
module trap_csr_decode
  import trap_csr_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] RW_BASE = 12'h7C0,
  parameter logic [11:0] RO_BASE = 12'hFC0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csr_dec_t          dec_o
);
  logic rw_hit, ro_hit;

  assign rw_hit = addr_i[ADDR_W-1:2] == RW_BASE[ADDR_W-1:2];
  assign ro_hit = addr_i[ADDR_W-1:2] == RO_BASE[ADDR_W-1:2];

  always_comb begin
    dec_o.hit = rw_hit | ro_hit;
    dec_o.ro  = ro_hit;
    dec_o.sel = csr_sel_e'(addr_i[1:0]);
  end
endmodule

// File: rtl/trap_csr_arbiter.sv
module trap_csr_arbiter
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            ext_irq_i,
  input  logic            meie_i,
  input  logic            illegal_i,
  input  logic            ebreak_i,
  input  logic            ecall_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);
  logic sw_trap;

  assign sw_trap = illegal_i | ebreak_i | ecall_i;
  assign take_o  = sw_trap | (ext_irq_i & meie_i);

  // fixed order: illegal > ebreak > ecall > external
  always_comb begin
    cause_o = '0;
    if (illegal_i)      cause_o[3:0] = CODE_ILLEGAL;
    else if (ebreak_i)  cause_o[3:0] = CODE_EBREAK;
    else if (ecall_i)   cause_o[3:0] = CODE_ECALL;
    else begin
      cause_o[XLEN-1] = 1'b1;
      cause_o[3:0]    = CODE_EXT_IRQ;
    end
  end
endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
  import trap_csr_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter int              ADDR_W       = 12,
  parameter logic [XLEN-1:0] VECT_DEFAULT = 32'h0000_0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_en_i,
  input  logic              csr_swap_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_illegal_o,
  input  logic              ext_irq_i,
  input  logic              illegal_instr_i,
  input  logic              ecall_i,
  input  logic              ebreak_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              mret_i,
  output logic              trap_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_pc_o
);
  localparam logic [XLEN-1:0] CAUSE_MASK = {1'b1, {(XLEN-5){1'b0}}, 4'hF};

  csr_dec_t        dec;
  logic            meie_q, meie_prev_q;
  logic [XLEN-1:0] cause_q, epc_q, evect_q;
  logic [XLEN-1:0] trap_cause;
  logic [XLEN-1:0] status_val;
  logic            wr_en;

  trap_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (csr_addr_i),
    .dec_o  (dec)
  );

  assign csr_illegal_o = csr_en_i & (~csr_swap_i | ~dec.hit);

  trap_csr_arbiter #(.XLEN(XLEN)) u_arbiter (
    .ext_irq_i (ext_irq_i),
    .meie_i    (meie_q),
    .illegal_i (illegal_instr_i | csr_illegal_o),
    .ebreak_i  (ebreak_i),
    .ecall_i   (ecall_i),
    .take_o    (trap_o),
    .cause_o   (trap_cause)
  );

  assign status_val = {{(XLEN-3){1'b0}}, ext_irq_i, meie_prev_q, meie_q};

  always_comb begin
    csr_rdata_o = '0;
    if (csr_en_i && dec.hit) begin
      unique case (dec.sel)
        SEL_STATUS: csr_rdata_o = status_val;
        SEL_CAUSE:  csr_rdata_o = cause_q;
        SEL_EPC:    csr_rdata_o = epc_q;
        SEL_EVECT:  csr_rdata_o = evect_q;
        default:    csr_rdata_o = '0;
      endcase
    end
  end

  assign wr_en       = csr_en_i & csr_swap_i & dec.hit & ~dec.ro & ~trap_o;
  assign redirect_o  = trap_o | mret_i;
  assign target_pc_o = trap_o ? evect_q : epc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meie_q      <= 1'b0;
      meie_prev_q <= 1'b0;
      cause_q     <= '0;
      epc_q       <= '0;
      evect_q     <= VECT_DEFAULT;
    end else if (trap_o) begin
      meie_prev_q <= meie_q;
      meie_q      <= 1'b0;
      cause_q     <= trap_cause;
      epc_q       <= pc_i;
    end else begin
      if (mret_i) meie_q <= meie_prev_q;
      if (wr_en) begin
        unique case (dec.sel)
          SEL_STATUS: begin
            meie_q      <= csr_wdata_i[0];
            meie_prev_q <= csr_wdata_i[1];
          end
          SEL_CAUSE: cause_q <= csr_wdata_i & CAUSE_MASK;
          SEL_EPC:   epc_q   <= csr_wdata_i;
          SEL_EVECT: evect_q <= csr_wdata_i;
          default: ;
        endcase
      end
    end
  end

  // R7
  meie_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> (!meie_q && meie_prev_q == $past(meie_q)));
  // R7
  epc_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> epc_q == $past(pc_i));
  // R10
  mret_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_o && !(wr_en && dec.sel == SEL_STATUS)) |=> meie_q == $past(meie_prev_q));
  // R3
  ro_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && dec.hit && dec.ro && !trap_o) |=> ($stable(epc_q) && $stable(evect_q) && $stable(cause_q)));
  // R9
  sw_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_instr_i || ecall_i || ebreak_i) |=> !cause_q[XLEN-1]);
  // R4
  csr_ill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |=> cause_q == XLEN'(CODE_ILLEGAL));
  // R11
  trap_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && csr_en_i) |=> $stable(evect_q));
endmodule

// File: tb/trap_csr_unit_bench.sv
module trap_csr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_en = 0, csr_swap = 0, ext_irq = 0, ill = 0, ecall = 0, ebreak = 0, mret = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, pc = '0;
  logic [31:0] csr_rdata, target_pc;
  logic        csr_illegal, trap, redirect;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // model state
  bit        m_meie, m_prev;
  bit [31:0] m_cause, m_epc, m_evect;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_csr_unit u_trap_csr_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_en_i(csr_en), .csr_swap_i(csr_swap), .csr_addr_i(csr_addr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .csr_illegal_o(csr_illegal),
    .ext_irq_i(ext_irq), .illegal_instr_i(ill), .ecall_i(ecall), .ebreak_i(ebreak),
    .pc_i(pc), .mret_i(mret), .trap_o(trap), .redirect_o(redirect), .target_pc_o(target_pc)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit [31:0] model_read(bit [1:0] idx, bit irq);
    case (idx)
      2'd0: return {29'd0, irq, m_prev, m_meie};
      2'd1: return m_cause;
      2'd2: return m_epc;
      default: return m_evect;
    endcase
  endfunction

  task automatic step(string tag, bit en, bit sw, bit [11:0] a, bit [31:0] wd,
                      bit irq, bit il, bit ec, bit eb, bit [31:0] p, bit mr);
    bit hit, ro, ill_csr, take;
    bit [31:0] exp_rd, code;
    @(negedge clk);
    csr_en = en; csr_swap = sw; csr_addr = a; csr_wdata = wd;
    ext_irq = irq; ill = il; ecall = ec; ebreak = eb; pc = p; mret = mr;
    #(CLK_PERIOD/4);
    ro      = a[11:2] == 10'h3F0;
    hit     = ro || (a[11:2] == 10'h1F0);
    ill_csr = en && (!sw || !hit);
    take    = il || ec || eb || ill_csr || (irq && m_meie);
    exp_rd  = (en && hit) ? model_read(a[1:0], irq) : 32'd0;
    if (il || ill_csr) code = 32'h2;
    else if (eb)       code = 32'h3;
    else if (ec)       code = 32'hB;
    else               code = 32'h8000_000B;
    check(tag, "rdata", csr_rdata, exp_rd);
    check(tag, "illegal", {31'd0, csr_illegal}, {31'd0, ill_csr});
    check(tag, "trap", {31'd0, trap}, {31'd0, take});
    check(tag, "redirect", {31'd0, redirect}, {31'd0, take || mr});
    if (take)    check(tag, "target(trap)", target_pc, m_evect);
    else if (mr) check(tag, "target(mret)", target_pc, m_epc);
    if (take) begin
      m_prev = m_meie; m_meie = 0; m_cause = code; m_epc = p;
    end else begin
      if (mr) m_meie = m_prev;
      if (en && sw && hit && !ro) begin
        case (a[1:0])
          2'd0: begin m_meie = wd[0]; m_prev = wd[1]; end
          2'd1: m_cause = wd & 32'h8000_000F;
          2'd2: m_epc = wd;
          default: m_evect = wd;
        endcase
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit [11:0] a;
    bit [31:0] r;
    m_meie = 0; m_prev = 0; m_cause = 0; m_epc = 0; m_evect = 32'h10;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values via read-only aliases
    for (int i = 0; i < 4; i++) step("R1", 1, 1, 12'hFC0 + 12'(i), 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    // R5 live irq bit, masked at reset (R8)
    step("R5", 1, 1, 12'hFC0, 0, 1, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0, 0, 0, 32'h100, 0);
    // R2 swap returns old and stores new
    step("R2", 1, 1, 12'h7C2, 32'h0000_1234, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 1, 12'hFC2, 32'h0, 0, 0, 0, 0, 0, 0);
    // R3 read-only alias discards write
    step("R3", 1, 1, 12'hFC3, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 12'hFC3, 32'h0, 0, 0, 0, 0, 0, 0);
    // R5 status write masks
    step("R5", 1, 1, 12'h7C0, 32'hFFFF_FFFC, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 1, 12'hFC0, 32'h0, 0, 0, 0, 0, 0, 0);
    // R6 cause field mask
    step("R6", 1, 1, 12'h7C1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 12'hFC1, 32'h0, 0, 0, 0, 0, 0, 0);
    // R4 illegal forms
    step("R4", 1, 0, 12'h7C0, 32'h3, 0, 0, 0, 0, 32'h200, 0);
    step("R4", 1, 1, 12'h7C4, 32'h3, 0, 0, 0, 0, 32'h204, 0);
    step("R4", 1, 1, 12'hFC1, 32'h0, 0, 0, 0, 0, 0, 0);
    // R8/R7 enabled external interrupt
    step("R8", 1, 1, 12'h7C0, 32'h1, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 0, 0, 0, 32'h300, 0);
    step("R7", 1, 1, 12'hFC0, 0, 1, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 12'hFC1, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R10", 1, 1, 12'hFC0, 0, 0, 0, 0, 0, 0, 0);
    // R9 priority
    step("R9", 0, 0, 0, 0, 1, 0, 1, 0, 32'h400, 0);
    step("R9", 1, 1, 12'hFC1, 0, 1, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 1, 1, 32'h404, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 1, 32'h408, 0);
    step("R9", 1, 1, 12'hFC1, 0, 0, 0, 0, 0, 0, 0);
    // R10 trap overrides mret
    step("R10", 0, 0, 0, 0, 0, 0, 1, 0, 32'h500, 1);
    // R11 write dropped on trapping cycle
    step("R11", 1, 1, 12'h7C3, 32'h0000_0F00, 0, 0, 1, 0, 32'h600, 0);
    step("R11", 1, 1, 12'hFC3, 0, 0, 0, 0, 0, 0, 0);
    // R12 new vector
    step("R12", 1, 1, 12'h7C3, 32'h0000_0400, 0, 0, 0, 0, 0, 0);
    step("R12", 0, 0, 0, 0, 0, 0, 0, 1, 32'h700, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      r = $urandom;
      a = (r[3:0] == 0) ? 12'($urandom) : {r[4] ? 4'hF : 4'h7, 6'h30, r[6:5]};
      step("R2", r[7] || r[8], r[9:12] != 0 ? 1'b1 : r[13], a, $urandom,
           r[14] & r[15], r[20:16] == 0, r[25:21] == 0, r[30:26] == 0,
           {$urandom, 2'b00} >> 2 << 2, r[31] & r[14] & ~r[15]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule